// File: doc/BRIEF.md
# Lockable Firmware Fetch Routing Register

This block holds one 32-bit control word that decides where firmware fetches go: to the SPI flash, to the LPC bus, to PCI, or to an unused reserved slot. While reset is held, the two-bit routing field is loaded from strap pins, and the same strap value is kept as a separate boot-location output. After reset, software may rewrite the routing field through a plain register write port until it sets a lock bit. From then on the field cannot change until the next reset.

Each firmware read request is steered by the routing field as it stands in the request cycle. The block raises the select strobe for that target in the same cycle. One cycle later it returns the target's data. If the target reports no device, or the field names the reserved slot, every returned bit is one. All register bits other than the field and the lock are plain read/write storage.

Top module: `fw_route_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register loads 32'h00C0_0000 with bits 11:10 set to `strap_sel` and bit 0 (the lock) cleared. For example, strap 01 reads as 32'h00C0_0400 and strap 11 reads as 32'h00C0_0C00.
- R2: `boot_loc` holds the strap value captured during reset, and register writes never change it.
- R3: While the register is unlocked, a write replaces every register bit with `reg_wdata`. The lock bit is the exception and follows R4. The new value is visible on `reg_rdata` after the write's clock edge.
- R4: The lock in bit 0 can only be set. Writing 1 sets it, writing 0 leaves it unchanged, and only reset clears it.
- R5: While the lock is 1, writes leave bits 11:10 unchanged, but all other non-lock bits still take the written data.
- R6: A write that sets the lock and changes bits 11:10 in the same cycle takes the new field value.
- R7: While `fw_rd_req` is high, exactly one strobe follows the field: 01 raises `spi_sel`, 11 raises `lpc_sel`, and 00 raises `pci_sel`. The value 10 (reserved) raises no strobe, and no strobe is raised while no request is present.
- R8: One cycle after a request, `fw_rd_valid` is high and `fw_rdata` equals the selected target's read data as sampled in the request cycle, provided that target's present flag was high.
- R9: The read returns all ones when the selected target's present flag was low in the request cycle, or when the field is 10.
- R10: A request is routed by the field value before any write in the same cycle. A write therefore redirects only requests made after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_sel | input | 2 | Strap pins giving the power-up routing value |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| boot_loc | output | 2 | Strap value captured at reset |
| fw_rd_req | input | 1 | Firmware read request |
| spi_sel | output | 1 | Request routed to SPI flash |
| lpc_sel | output | 1 | Request routed to LPC |
| pci_sel | output | 1 | Request routed to PCI |
| spi_rdata | input | 32 | SPI target read data |
| spi_present | input | 1 | SPI target has a device |
| lpc_rdata | input | 32 | LPC target read data |
| lpc_present | input | 1 | LPC target has a device |
| pci_rdata | input | 32 | PCI target read data |
| pci_present | input | 1 | PCI target has a device |
| fw_rd_valid | output | 1 | Read data valid, one cycle after request |
| fw_rdata | output | 32 | Routed read data, or all ones |

## Verification
A corrupted routing field is visible on `reg_rdata` in the first cycle after the bad write. The next request then raises the wrong strobe in its own cycle. A lost or cleared lock bit shows up only when a later write is accepted, so the tests always follow the lock with a field write and a read-back. A wrong capture in the read path appears on `fw_rdata` exactly one cycle after the request. Absent and reserved targets are compared against all ones at that point.

// File: rtl/fw_route_pkg.sv
// Shared definitions for the firmware routing register.
// Assumes a two-bit routing code; the target index equals the code value.
package fw_route_pkg;
    localparam int TGT_N = 4;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        TGT_PCI  = 2'b00,
        TGT_SPI  = 2'b01,
        TGT_RSVD = 2'b10,
        TGT_LPC  = 2'b11
    } fw_tgt_e;
endpackage

// File: rtl/fw_route_reg.sv
// Control word with a strap-loaded routing field and a set-only lock.
// Assumes synchronous active-low reset held for at least one edge with
// the straps valid. The field is frozen while the lock is 1; the lock
// value from before the write decides, so the locking write still lands.
module fw_route_reg #(
    parameter int REG_W = 32,
    parameter int FLD_LSB = 10,
    parameter int FLD_W = 2,
    parameter int LOCK_POS = 0,
    parameter logic [REG_W-1:0] RST_VAL = 32'h00C0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] strap_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [FLD_W-1:0] field,
    output logic [FLD_W-1:0] boot_loc
);
    localparam logic [REG_W-1:0] FLD_MASK =
        {{(REG_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << FLD_LSB;
    localparam logic [REG_W-1:0] LOCK_MASK =
        {{(REG_W-1){1'b0}}, 1'b1} << LOCK_POS;
    localparam logic [REG_W-1:0] PLAIN_MASK = ~(FLD_MASK | LOCK_MASK);

    logic [REG_W-1:0] plain_q;
    logic [FLD_W-1:0] field_q;
    logic [FLD_W-1:0] boot_q;
    logic             lock_q;

    // Plain storage bits: reset constant, then any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            plain_q <= RST_VAL & PLAIN_MASK;
        else if (wr_en)
            plain_q <= wdata & PLAIN_MASK;
    end

    // Routing field: strap at reset, writable until locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_q <= strap_sel;
        else if (wr_en && !lock_q)
            field_q <= wdata[FLD_LSB +: FLD_W];
    end

    // Lock: cleared by reset only, set by writing a 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (wr_en && wdata[LOCK_POS])
            lock_q <= 1'b1;
    end

    // Boot location: strap copy that only reset can refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boot_q <= strap_sel;
    end

    // Assemble the visible register word.
    always_comb begin
        rdata = plain_q;
        rdata[FLD_LSB +: FLD_W] = field_q;
        rdata[LOCK_POS] = lock_q;
    end

    assign field = field_q;
    assign boot_loc = boot_q;
endmodule

// File: rtl/fw_route_decode.sv
// Turns the routing code into one strobe per target slot, gated by the
// request. Assumes slot index equals code value.
module fw_route_decode #(
    parameter int TGT_N = fw_route_pkg::TGT_N,
    parameter int CODE_W = fw_route_pkg::CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              req,
    output logic [TGT_N-1:0]  sel
);
    // One comparator per slot.
    for (genvar g = 0; g < TGT_N; g++) begin : g_slot
        assign sel[g] = req && (code == CODE_W'(g));
    end
endmodule

// File: rtl/fw_route_rdmux.sv
// Registers the routed read result one cycle after the request.
// Assumes target data and present flags are valid in the request cycle.
// A slot whose present flag is low yields all ones.
module fw_route_rdmux #(
    parameter int TGT_N = fw_route_pkg::TGT_N,
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic [TGT_N-1:0]          sel,
    input  logic [TGT_N-1:0]          present,
    input  logic [TGT_N-1:0][DW-1:0]  tdata,
    output logic                      valid,
    output logic [DW-1:0]             rdata
);
    logic [DW-1:0] pick;
    logic          hit;
    logic [DW-1:0] data_q;
    logic          hit_q;
    logic          valid_q;

    // OR together the data of the selected, populated slot.
    always_comb begin
        pick = '0;
        hit = 1'b0;
        for (int i = 0; i < TGT_N; i++) begin
            if (sel[i] && present[i]) begin
                pick = pick | tdata[i];
                hit = 1'b1;
            end
        end
    end

    // Capture the result on a request; valid pulses the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            hit_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req;
            if (req) begin
                data_q <= pick;
                hit_q <= hit;
            end
        end
    end

    assign valid = valid_q;
    assign rdata = hit_q ? data_q : '1;
endmodule

// File: rtl/fw_route_ctrl.sv
// Top: lockable routing register plus firmware read steering.
// Assumes a single requester; the reserved slot never has a device.
module fw_route_ctrl #(
    parameter int REG_W = 32,
    parameter int FW_DW = 32,
    parameter int FLD_LSB = 10,
    parameter int LOCK_POS = 0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [fw_route_pkg::CODE_W-1:0]    strap_sel,
    input  logic                               reg_wr_en,
    input  logic [REG_W-1:0]                   reg_wdata,
    output logic [REG_W-1:0]                   reg_rdata,
    output logic [fw_route_pkg::CODE_W-1:0]    boot_loc,
    input  logic                               fw_rd_req,
    output logic                               spi_sel,
    output logic                               lpc_sel,
    output logic                               pci_sel,
    input  logic [FW_DW-1:0]                   spi_rdata,
    input  logic                               spi_present,
    input  logic [FW_DW-1:0]                   lpc_rdata,
    input  logic                               lpc_present,
    input  logic [FW_DW-1:0]                   pci_rdata,
    input  logic                               pci_present,
    output logic                               fw_rd_valid,
    output logic [FW_DW-1:0]                   fw_rdata
);
    import fw_route_pkg::*;

    logic [CODE_W-1:0]            code;
    logic [TGT_N-1:0]             sel;
    logic [TGT_N-1:0]             present;
    logic [TGT_N-1:0][FW_DW-1:0]  tdata;

    fw_route_reg #(
        .REG_W(REG_W), .FLD_LSB(FLD_LSB), .FLD_W(CODE_W),
        .LOCK_POS(LOCK_POS), .RST_VAL(REG_W'(32'h00C0_0000))
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel),
        .wr_en(reg_wr_en), .wdata(reg_wdata), .rdata(reg_rdata),
        .field(code), .boot_loc(boot_loc)
    );

    fw_route_decode #(.TGT_N(TGT_N), .CODE_W(CODE_W)) u_dec (
        .code(code), .req(fw_rd_req), .sel(sel)
    );

    // Slot wiring: index equals routing code.
    always_comb begin
        present = '0;
        tdata = '1;
        present[TGT_PCI] = pci_present;
        tdata[TGT_PCI] = pci_rdata;
        present[TGT_SPI] = spi_present;
        tdata[TGT_SPI] = spi_rdata;
        present[TGT_LPC] = lpc_present;
        tdata[TGT_LPC] = lpc_rdata;
    end

    fw_route_rdmux #(.TGT_N(TGT_N), .DW(FW_DW)) u_mux (
        .clk(clk), .rst_n(rst_n), .req(fw_rd_req), .sel(sel),
        .present(present), .tdata(tdata),
        .valid(fw_rd_valid), .rdata(fw_rdata)
    );

    assign spi_sel = sel[TGT_SPI];
    assign lpc_sel = sel[TGT_LPC];
    assign pci_sel = sel[TGT_PCI];
endmodule

// File: rtl/fw_route_ctrl_chk.sv
// Port-level properties of fw_route_ctrl, attached by bind.
module fw_route_ctrl_chk #(
    parameter int REG_W = 32,
    parameter int FW_DW = 32,
    parameter int FLD_LSB = 10,
    parameter int LOCK_POS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        strap_sel,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [1:0]        boot_loc,
    input logic              fw_rd_req,
    input logic              spi_sel,
    input logic              lpc_sel,
    input logic              pci_sel,
    input logic [FW_DW-1:0]  spi_rdata,
    input logic              spi_present,
    input logic [FW_DW-1:0]  lpc_rdata,
    input logic              lpc_present,
    input logic [FW_DW-1:0]  pci_rdata,
    input logic              pci_present,
    input logic              fw_rd_valid,
    input logic [FW_DW-1:0]  fw_rdata
);
    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[LOCK_POS] |=> reg_rdata[LOCK_POS]);

    // R5
    field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[LOCK_POS] |=> $stable(reg_rdata[FLD_LSB +: 2]));

    // R2
    boot_loc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_loc));

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spi_sel, lpc_sel, pci_sel}));

    // R7
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_rd_req |-> !(spi_sel || lpc_sel || pci_sel));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_rd_req |=> fw_rd_valid);

    // R9
    rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_rd_req && reg_rdata[FLD_LSB +: 2] == 2'b10) |=> (fw_rdata == '1));
endmodule

bind fw_route_ctrl fw_route_ctrl_chk #(
    .REG_W(REG_W), .FW_DW(FW_DW), .FLD_LSB(FLD_LSB), .LOCK_POS(LOCK_POS)
) u_chk (.*);

// File: tb/fw_route_ctrl_bench.sv
module fw_route_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_sel = 2'b01;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  boot_loc;
    logic        fw_rd_req = 1'b0;
    logic        spi_sel, lpc_sel, pci_sel;
    logic [31:0] spi_rdata = 32'h5151_0001;
    logic [31:0] lpc_rdata = 32'h1C1C_0002;
    logic [31:0] pci_rdata = 32'h9C19_0003;
    logic        spi_present = 1'b1;
    logic        lpc_present = 1'b1;
    logic        pci_present = 1'b1;
    logic        fw_rd_valid;
    logic [31:0] fw_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fw_route_ctrl u_fw_route_ctrl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_sel = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        strap_sel = ~strap;
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Request one read; check strobes in the request cycle, data one later.
    task automatic fw_read(input string tag, input logic [2:0] exp_sel, input logic [31:0] exp_data);
        @(negedge clk);
        fw_rd_req = 1'b1;
        #1;
        check({tag, " strobes"}, {29'b0, spi_sel, lpc_sel, pci_sel}, {29'b0, exp_sel});
        @(negedge clk);
        fw_rd_req = 1'b0;
        check({tag, " valid"}, {31'b0, fw_rd_valid}, 32'd1);
        check({tag, " data"}, fw_rdata, exp_data);
    endtask

    task automatic t_reset_state;
        // R1 R2
        do_reset(2'b01);
        check("R1 reset value", reg_rdata, 32'h00C0_0400);
        check("R2 boot loc", {30'b0, boot_loc}, 32'd1);
        check("R8 idle valid", {31'b0, fw_rd_valid}, 32'd0);
    endtask

    task automatic t_rewrite;
        // R3 R2 R7 R8
        reg_write(32'h00C0_0C40);
        check("R3 rewrite to LPC", reg_rdata, 32'h00C0_0C40);
        check("R2 boot loc after write", {30'b0, boot_loc}, 32'd1);
        fw_read("R7 R8 LPC", 3'b010, 32'h1C1C_0002);
        reg_write(32'h0000_0400);
        check("R3 plain bits", reg_rdata, 32'h0000_0400);
        fw_read("R7 R8 SPI", 3'b100, 32'h5151_0001);
        reg_write(32'h0000_0000);
        fw_read("R7 R8 PCI", 3'b001, 32'h9C19_0003);
    endtask

    task automatic t_empty_targets;
        // R9
        pci_present = 1'b0;
        fw_read("R9 PCI absent", 3'b001, 32'hFFFF_FFFF);
        pci_present = 1'b1;
        reg_write(32'h0000_0800);
        fw_read("R9 reserved", 3'b000, 32'hFFFF_FFFF);
        reg_write(32'h0000_0C00);
        lpc_present = 1'b0;
        fw_read("R9 LPC absent", 3'b010, 32'hFFFF_FFFF);
        lpc_present = 1'b1;
    endtask

    task automatic t_route_timing;
        // R10: request in the write cycle uses the old route
        reg_write(32'h0000_0400);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = 32'h0000_0C00;
        fw_rd_req = 1'b1;
        #1;
        check("R10 old route strobes", {29'b0, spi_sel, lpc_sel, pci_sel}, 32'd4);
        @(negedge clk);
        reg_wr_en = 1'b0;
        fw_rd_req = 1'b0;
        check("R10 old route data", fw_rdata, 32'h5151_0001);
        fw_read("R10 new route", 3'b010, 32'h1C1C_0002);
    endtask

    task automatic t_lock;
        // R6: locking write moves field LPC -> SPI
        reg_write(32'h00C0_0441);
        check("R6 same-cycle lock", reg_rdata, 32'h00C0_0441);
        // R5: field frozen, other bits writable; R4 zero does not clear
        reg_write(32'h1234_5C40);
        check("R5 R4 locked write", reg_rdata, 32'h1234_5441);
        reg_write(32'h0000_0000);
        check("R4 lock holds", reg_rdata, 32'h0000_0401);
        fw_read("R5 route after lock", 3'b100, 32'h5151_0001);
        // R1 R4: reset clears lock, new strap
        do_reset(2'b11);
        check("R1 strap 11", reg_rdata, 32'h00C0_0C00);
        check("R2 boot loc 11", {30'b0, boot_loc}, 32'd3);
        reg_write(32'h0000_0000);
        check("R4 unlocked after reset", reg_rdata, 32'h0000_0000);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_rewrite();
        t_empty_targets();
        t_route_timing();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule